// File: doc/BRIEF.md
# Early-Exit Iterative Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor, one quotient bit per clock, and returns both quotient and remainder. A single-cycle start pulse loads the operands together with a mode bit that selects signed or unsigned division. While it works the block holds a busy flag. When it finishes it raises a one-cycle done pulse, and the results stay on the outputs until the next divide completes.

Latency depends on the data. A setup cycle takes the magnitudes of both operands and counts the leading zeros of the dividend magnitude. It also left-aligns the dividend, so the loop only runs for as many steps as the dividend has significant bits. A final cycle applies the signs. A small dividend therefore occupies the unit for only a few cycles. A dividend magnitude with its top bit set needs the full 34 cycles.

Top module: `dv_divider`

## Requirements
- R1: With `is_signed` low, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both treated as unsigned 32-bit values, for any non-zero divisor.
- R2: With `is_signed` high, the operands are two's complement. The quotient is truncated toward zero, which makes it negative exactly when the operand signs differ, and a non-zero remainder carries the sign of the dividend.
- R3: `busy` goes high in the cycle after an accepted start and stays high for exactly 34 − z cycles, where z is the leading-zero count of the dividend magnitude (the magnitude is the two's complement absolute value in signed mode). The longest run is 34 cycles.
- R4: `done` is high for exactly one cycle, which is the first cycle after `busy` falls. In that cycle `quotient` and `remainder` already hold the new result.
- R5: The dividend, divisor and `is_signed` are sampled only in the cycle in which start is accepted. Later changes to them do not affect the result.
- R6: A start pulse while `busy` is high is ignored. The running divide keeps its length and its result.
- R7: A zero divisor returns an all-ones quotient (0xFFFFFFFF) and a remainder equal to the raw dividend, in either mode, with `busy` high for 2 cycles.
- R8: A zero dividend with a non-zero divisor returns quotient 0 and remainder 0, with `busy` high for 2 cycles.
- R9: In signed mode, dividend 0x80000000 divided by 0xFFFFFFFF (−1) returns quotient 0x80000000 and remainder 0.
- R10: During and directly after reset, `busy` and `done` are low and `quotient` and `remainder` are 0.
- R11: `quotient` and `remainder` change only in a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide; accepted only while not busy |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled with start |
| divisor | input | 32 | Divisor, sampled with start |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| quotient | output | 32 | Quotient of the last completed divide |
| remainder | output | 32 | Remainder of the last completed divide |

## Verification
The bench builds the divider with the default width of 32. This width makes the 34-cycle worst case reachable, along with the most negative dividend and the all-ones divisor that appears as −1 in signed mode. With these values every loop length from 2 to 34 cycles can be set up by choosing the dividend magnitude. The vectors pair each result with its exact cycle count, so a divide that stops one step early or late is caught even when its quotient looks plausible.

// File: rtl/dv_pkg.sv
package dv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIX   = 2'd3
    } dv_state_e;
endpackage

// File: rtl/dv_abs.sv
// Two's complement magnitude with a sign flag; sign ignored when unsigned.
module dv_abs #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         sgn_en,
    output logic [W-1:0] mag,
    output logic         neg
);
    always_comb begin
        neg = sgn_en & val[W-1];
        mag = neg ? (~val + W'(1)) : val;
    end
endmodule

// File: rtl/dv_lzc.sv
// Leading-zero counter; returns W for an all-zero input.
module dv_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (val[i]) zeros = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/dv_step.sv
// One restoring-division step: shift in next dividend bit, trial subtract.
module dv_step #(
    parameter int W = 32
) (
    input  logic [W:0]   rem_in,
    input  logic [W-1:0] dvd_in,
    input  logic [W-1:0] dsr,
    output logic [W:0]   rem_out,
    output logic [W-1:0] dvd_out
);
    logic [W:0]   shifted;
    logic [W+1:0] diff;
    logic         fits;

    always_comb begin
        shifted = {rem_in[W-1:0], dvd_in[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dsr};
        fits    = ~diff[W+1];
        rem_out = fits ? diff[W:0] : shifted;
        dvd_out = {dvd_in[W-2:0], fits};
    end
endmodule

// File: rtl/dv_divider.sv
module dv_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    import dv_pkg::*;

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        dv_state_e   st;
        logic [W-1:0]  a;     // raw dividend
        logic [W-1:0]  b;     // raw divisor, then divisor magnitude
        logic          sg;
        logic          nq;    // negate quotient
        logic          nr;    // negate remainder
        logic          dz;    // divisor was zero
        logic [CW-1:0] cnt;   // steps left
        logic [W-1:0]  dvd;   // aligned dividend / quotient bits
        logic [W:0]    rem;
        logic [W-1:0]  q;
        logic [W-1:0]  r;
        logic          dn;
    } dv_regs_t;

    dv_regs_t s_d, s_q;

    logic [W-1:0]  a_mag, b_mag;
    logic          a_neg, b_neg;
    logic [CW-1:0] a_lz;
    logic [W:0]    step_rem;
    logic [W-1:0]  step_dvd;

    dv_abs #(.W(W)) u_abs_a (
        .val(s_q.a), .sgn_en(s_q.sg), .mag(a_mag), .neg(a_neg)
    );

    dv_abs #(.W(W)) u_abs_b (
        .val(s_q.b), .sgn_en(s_q.sg), .mag(b_mag), .neg(b_neg)
    );

    dv_lzc #(.W(W), .CW(CW)) u_lzc (
        .val(a_mag), .zeros(a_lz)
    );

    dv_step #(.W(W)) u_step (
        .rem_in (s_q.rem),
        .dvd_in (s_q.dvd),
        .dsr    (s_q.b),
        .rem_out(step_rem),
        .dvd_out(step_dvd)
    );

    always_comb begin
        s_d    = s_q;
        s_d.dn = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.a  = dividend;
                    s_d.b  = divisor;
                    s_d.sg = is_signed;
                    s_d.st = ST_SETUP;
                end
            end
            ST_SETUP: begin
                s_d.nq  = a_neg ^ b_neg;
                s_d.nr  = a_neg;
                s_d.dz  = (b_mag == '0);
                s_d.b   = b_mag;
                s_d.dvd = a_mag << a_lz;
                s_d.rem = '0;
                s_d.cnt = CW'(W) - a_lz;
                if ((b_mag == '0) || (a_lz == CW'(W))) s_d.st = ST_FIX;
                else                                   s_d.st = ST_ITER;
            end
            ST_ITER: begin
                s_d.rem = step_rem;
                s_d.dvd = step_dvd;
                s_d.cnt = s_q.cnt - CW'(1);
                if (s_q.cnt == CW'(1)) s_d.st = ST_FIX;
            end
            ST_FIX: begin
                if (s_q.dz) begin
                    s_d.q = '1;
                    s_d.r = s_q.a;
                end else begin
                    s_d.q = s_q.nq ? (~s_q.dvd + W'(1)) : s_q.dvd;
                    s_d.r = s_q.nr ? (~s_q.rem[W-1:0] + W'(1)) : s_q.rem[W-1:0];
                end
                s_d.dn = 1'b1;
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign done      = s_q.dn;
    assign quotient  = s_q.q;
    assign remainder = s_q.r;
endmodule

// File: rtl/dv_divider_chk.sv
module dv_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder
);
    localparam int LW = $clog2(W + 3) + 1;

    logic [LW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + LW'(1);
        else           run_q <= '0;
    end

    // R4: done only once busy has dropped
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4: every falling busy comes with done
    a_r4_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: single-cycle pulse
    a_r4_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: accepted start makes the unit busy next cycle
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3: at least two busy cycles
    a_r3_min_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R3: never longer than W + 2 cycles
    a_r3_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < LW'(W + 2)));

    // R11: results only move with done
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

bind dv_divider dv_divider_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .quotient (quotient),
    .remainder(remainder)
);

// File: tb/dv_divider_tb.sv
module dv_divider_tb;
    localparam int W = 32;
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    // {is_signed, dividend, divisor}
    localparam logic [2*W:0] VEC [10] = '{
        {1'b0, 32'd100,        32'd7},
        {1'b0, 32'hFFFF_FFFF,  32'd1},
        {1'b0, 32'h8000_0000,  32'd3},
        {1'b0, 32'd5,          32'd10},
        {1'b0, 32'h1234_5678,  32'h0000_1234},
        {1'b1, 32'hFFFF_FF9C,  32'd7},
        {1'b1, 32'd100,        32'hFFFF_FFF9},
        {1'b1, 32'hFFFF_FF9C,  32'hFFFF_FFF9},
        {1'b1, 32'd1,          32'd1},
        {1'b1, 32'h7FFF_FFFF,  32'hFFFF_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         is_signed = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dv_divider #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] x, input logic [W-1:0] y,
                                  input logic s, output logic [W-1:0] eq,
                                  output logic [W-1:0] er, output int ec);
        logic [W-1:0] mag;
        int lz;
        mag = (s && x[W-1]) ? (~x + 1) : x;
        lz = W;
        for (int i = 0; i < W; i++) if (mag[i]) lz = W - 1 - i;
        if (y == '0) begin
            eq = '1; er = x; ec = 2;
        end else if (s && x == MINV && y == '1) begin
            eq = MINV; er = '0; ec = W + 2 - lz;
        end else if (s) begin
            eq = $signed(x) / $signed(y);
            er = $signed(x) % $signed(y);
            ec = W + 2 - lz;
        end else begin
            eq = x / y; er = x % y; ec = W + 2 - lz;
        end
    endfunction

    task automatic run_div(input logic [W-1:0] ta, input logic [W-1:0] tb_,
                           input logic ts, input bit poke, input string req);
        logic [W-1:0] eq, er;
        int ec, cnt;
        model(ta, tb_, ts, eq, er, ec);
        @(negedge clk);
        dividend = ta; divisor = tb_; is_signed = ts; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R5: scramble operands after the start cycle
        dividend = ~ta; divisor = tb_ ^ 32'h5A5A_5A5A; is_signed = ~ts;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            start = poke && (cnt == 3);
            if (start) begin dividend = 32'd9; divisor = 32'd3; end
            @(negedge clk);
        end
        start = 1'b0;
        chk(cnt == ec, req, "busy cycles (R3)", W'(cnt), W'(ec));
        chk(done === 1'b1, req, "done after busy (R4)", W'(done), W'(1));
        chk(quotient === eq, req, "quotient", quotient, eq);
        chk(remainder === er, req, "remainder", remainder, er);
        @(negedge clk);
        chk(done === 1'b0, req, "done single pulse (R4)", W'(done), W'(0));
        chk(quotient === eq && remainder === er, req, "result held (R11)",
            quotient, eq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done in reset",
            W'({busy, done}), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done after reset",
            W'({busy, done}), W'(0));
        chk(quotient === '0 && remainder === '0, "R10", "results after reset",
            quotient | remainder, '0);

        // R1 unsigned, R2 signed, with R3 timing and R5 scrambling
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][2*W]) run_div(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b1, 1'b0, "R2");
            else             run_div(VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0, 1'b0, "R1");
        end

        // R3 worst case, R6 start while busy ignored
        run_div(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1, "R6");
        run_div(MINV, 32'd7, 1'b1, 1'b1, "R6");

        // R7 zero divisor
        run_div(32'd1234, 32'd0, 1'b0, 1'b0, "R7");
        run_div(32'hFFFF_FF00, 32'd0, 1'b1, 1'b0, "R7");
        run_div(32'd0, 32'd0, 1'b0, 1'b0, "R7");

        // R8 zero dividend
        run_div(32'd0, 32'd55, 1'b0, 1'b0, "R8");
        run_div(32'd0, 32'hFFFF_FFFD, 1'b1, 1'b0, "R8");

        // R9 most negative over minus one
        run_div(MINV, 32'hFFFF_FFFF, 1'b1, 1'b0, "R9");

        // R3 mid-length and R5 check: start accepted right after done
        run_div(32'h0000_0100, 32'd3, 1'b0, 1'b0, "R3");
        run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R5");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule